// File: doc/BRIEF.md
# Dual-Select Byte-Lane Static Memory

This block is a word-organised memory whose control pins behave like those of an asynchronous static RAM, with every control input sampled on a clock edge. The device is enabled only when two chip selects of opposite polarity are both active. Separate active-low write and output enables, together with two active-low byte-lane enables, choose between writing, reading and idling. Each lane can be masked on its own for both writes and reads.

The bidirectional bus is split into a write-data input, a read-data output and one drive flag per lane. A wrapper on an FPGA, or a testbench, can turn these into tri-state pads. A small controller holds the access mode as an enumerated state. There are four states: STANDBY, IDLE, READ and WRITE. The mode is chosen anew from the inputs on every clock edge, and any state can move to any other. The chosen mode sets the write strobes, the read strobes, the lane drive flags and the standby flag.

The default address is 20 bits wide and the default word is 16 bits wide. The storage depth is a separate parameter, 1024 words by default. The word index is the address taken modulo the depth.

Top module: `sram_dual_select`

## Requirements
- R1: The device is selected only when `chip_sel_n` is 0 and `chip_sel` is 1. In every other combination it performs no write and drives no lane, whatever the other inputs are.
- R2: When the device is selected and `wr_n` is 0, the lower lane (`lane_en_n[0]` = 0) stores `wdata[7:0]` at the clock edge. Under the same condition the upper lane (`lane_en_n[1]` = 0) stores `wdata[15:8]`.
- R3: During a write, a lane whose enable bit is 1 keeps its stored contents unchanged.
- R4: A read takes place when the device is selected, `rd_oe_n` is 0 and `wr_n` is 1. One clock after the read is sampled, each enabled lane sets its `lane_drive` bit and shows the stored byte on `rdata`. Bit 0 is the lower lane and bit 1 is the upper lane.
- R5: During a read, a lane whose enable bit is 1 keeps its `lane_drive` bit at 0 while the other lane drives.
- R6: Both `lane_drive` bits are 0 one clock after any of these conditions is sampled: the device is deselected, `rd_oe_n` is 1, both lane enables are 1, or a write is taking place.
- R7: When `wr_n` and `rd_oe_n` are both 0 while the device is selected, the cycle is a write and no lane drives.
- R8: `standby` is 1 one clock after a cycle in which the device is deselected or both lane enables are 1. In every other case it is 0 one clock after the cycle.
- R9: While reset is asserted, `standby` is 1 and both `lane_drive` bits are 0.
- R10: The word index is `addr` modulo DEPTH, where DEPTH is a power of two. Addresses that differ only above that range refer to the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_sel_n | input | 1 | Active-low chip select |
| chip_sel | input | 1 | Active-high chip select |
| wr_n | input | 1 | Active-low write enable |
| rd_oe_n | input | 1 | Active-low output enable |
| lane_en_n | input | 2 | Active-low byte-lane enables; bit 0 is the lower byte, bit 1 the upper byte |
| addr | input | ADDR_W | Word address |
| wdata | input | 2*LANE_W | Write data |
| rdata | output | 2*LANE_W | Read data, valid only in lanes whose drive bit is 1 |
| lane_drive | output | 2 | Per-lane drive flag for external tri-state buffers |
| standby | output | 1 | Standby status flag |

## Verification
The assertions assume that every control input is settled at each rising clock edge and that nothing is undefined after reset. They also assume that each output reflects only the previous cycle's controls, so each property looks exactly one cycle back. The stimulus meets these assumptions by changing every input only on the falling clock edge and by driving known values from time zero. It sweeps all 64 combinations of the six control bits against reference storage kept in the bench. Every write goes to a word whose expected contents the bench already knows.

// File: rtl/sram_pkg.sv
package sram_pkg;

    typedef enum logic [1:0] {
        ST_STANDBY = 2'd0,
        ST_IDLE    = 2'd1,
        ST_READ    = 2'd2,
        ST_WRITE   = 2'd3
    } mode_t;

    localparam int NUM_LANES = 2;

endpackage

// File: rtl/sram_mode_fsm.sv
module sram_mode_fsm
    import sram_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 chip_sel_n,
    input  logic                 chip_sel,
    input  logic                 wr_n,
    input  logic                 rd_oe_n,
    input  logic [NUM_LANES-1:0] lane_en_n,
    output logic [NUM_LANES-1:0] wr_strobe,
    output logic [NUM_LANES-1:0] rd_strobe,
    output mode_t                mode_q,
    output logic [NUM_LANES-1:0] lane_act_q
);

    logic  selected;
    logic  all_lanes_off;
    mode_t mode_nxt;

    assign selected      = !chip_sel_n && chip_sel;
    assign all_lanes_off = &lane_en_n;

    // Next-mode decode: standby first, write over read, read over idle.
    always_comb begin
        if (!selected || all_lanes_off) begin
            mode_nxt = ST_STANDBY;
        end else if (!wr_n) begin
            mode_nxt = ST_WRITE;
        end else if (!rd_oe_n) begin
            mode_nxt = ST_READ;
        end else begin
            mode_nxt = ST_IDLE;
        end
    end

    always_comb begin
        for (int i = 0; i < NUM_LANES; i++) begin
            wr_strobe[i] = (mode_nxt == ST_WRITE) && !lane_en_n[i];
            rd_strobe[i] = (mode_nxt == ST_READ)  && !lane_en_n[i];
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q     <= ST_STANDBY;
            lane_act_q <= '0;
        end else begin
            mode_q     <= mode_nxt;
            lane_act_q <= ~lane_en_n;
        end
    end

endmodule

// File: rtl/sram_lane_bank.sv
module sram_lane_bank #(
    parameter int DEPTH  = 1024,
    parameter int LANE_W = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic [LANE_W-1:0] wbyte,
    output logic [LANE_W-1:0] rbyte
);

    logic [LANE_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            store[idx] <= wbyte;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rbyte <= '0;
        end else if (rd_en) begin
            rbyte <= store[idx];
        end
    end

endmodule

// File: rtl/sram_out_stage.sv
module sram_out_stage
    import sram_pkg::*;
(
    input  mode_t                mode_q,
    input  logic [NUM_LANES-1:0] lane_act_q,
    output logic [NUM_LANES-1:0] lane_drive,
    output logic                 standby
);

    // Output process driven from the registered state
    always_comb begin
        unique case (mode_q)
            ST_STANDBY: begin
                standby    = 1'b1;
                lane_drive = '0;
            end
            ST_IDLE: begin
                standby    = 1'b0;
                lane_drive = '0;
            end
            ST_WRITE: begin
                standby    = 1'b0;
                lane_drive = '0;
            end
            ST_READ: begin
                standby    = 1'b0;
                lane_drive = lane_act_q;
            end
            default: begin
                standby    = 1'b1;
                lane_drive = '0;
            end
        endcase
    end

endmodule

// File: rtl/sram_dual_select.sv
module sram_dual_select
    import sram_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int LANE_W = 8,
    parameter int DEPTH  = 1024,
    localparam int DATA_W = NUM_LANES * LANE_W,
    localparam int IDX_W  = $clog2(DEPTH)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 chip_sel_n,
    input  logic                 chip_sel,
    input  logic                 wr_n,
    input  logic                 rd_oe_n,
    input  logic [NUM_LANES-1:0] lane_en_n,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DATA_W-1:0]    wdata,
    output logic [DATA_W-1:0]    rdata,
    output logic [NUM_LANES-1:0] lane_drive,
    output logic                 standby
);

    logic [NUM_LANES-1:0] wr_strobe;
    logic [NUM_LANES-1:0] rd_strobe;
    logic [NUM_LANES-1:0] lane_act_q;
    mode_t                mode_q;
    logic [IDX_W-1:0]     word_idx;

    assign word_idx = IDX_W'(addr % ADDR_W'(DEPTH));

    sram_mode_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .chip_sel_n (chip_sel_n),
        .chip_sel   (chip_sel),
        .wr_n       (wr_n),
        .rd_oe_n    (rd_oe_n),
        .lane_en_n  (lane_en_n),
        .wr_strobe  (wr_strobe),
        .rd_strobe  (rd_strobe),
        .mode_q     (mode_q),
        .lane_act_q (lane_act_q)
    );

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        sram_lane_bank #(
            .DEPTH  (DEPTH),
            .LANE_W (LANE_W)
        ) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_en (wr_strobe[g]),
            .rd_en (rd_strobe[g]),
            .idx   (word_idx),
            .wbyte (wdata[g*LANE_W +: LANE_W]),
            .rbyte (rdata[g*LANE_W +: LANE_W])
        );
    end

    sram_out_stage u_out (
        .mode_q     (mode_q),
        .lane_act_q (lane_act_q),
        .lane_drive (lane_drive),
        .standby    (standby)
    );

endmodule

// File: rtl/sram_dual_select_chk.sv
module sram_dual_select_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       chip_sel_n,
    input logic       chip_sel,
    input logic       wr_n,
    input logic       rd_oe_n,
    input logic [1:0] lane_en_n,
    input logic [1:0] lane_drive,
    input logic       standby
);

    logic sel_in;
    assign sel_in = !chip_sel_n && chip_sel;

    p_reset_quiet_r9: assert property (@(posedge clk)
        !rst_n |-> (standby && lane_drive == 2'b00));

    p_desel_no_drive_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_in |=> (lane_drive == 2'b00 && standby));

    p_write_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_in && !wr_n && !rd_oe_n) |=> lane_drive == 2'b00);

    p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_oe_n || &lane_en_n) |=> lane_drive == 2'b00);

    p_read_lanes_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_in && wr_n && !rd_oe_n) |=> lane_drive == $past(~lane_en_n));

    p_lane_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
        lane_en_n[1] |=> !lane_drive[1]);

    p_standby_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_in && !(&lane_en_n)) |=> !standby);

endmodule

bind sram_dual_select sram_dual_select_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .chip_sel_n (chip_sel_n),
    .chip_sel   (chip_sel),
    .wr_n       (wr_n),
    .rd_oe_n    (rd_oe_n),
    .lane_en_n  (lane_en_n),
    .lane_drive (lane_drive),
    .standby    (standby)
);

// File: tb/tb_sram_dual_select.sv
`timescale 1ns/1ps
module tb_sram_dual_select;

    localparam int AW    = 20;
    localparam int DEPTH = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        chip_sel_n = 1'b1;
    logic        chip_sel = 1'b0;
    logic        wr_n = 1'b1;
    logic        rd_oe_n = 1'b1;
    logic [1:0]  lane_en_n = 2'b11;
    logic [AW-1:0] addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic [1:0]  lane_drive;
    logic        standby;

    logic [15:0] ref_mem [DEPTH];
    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #5 clk = ~clk;

    sram_dual_select dut (
        .clk(clk), .rst_n(rst_n), .chip_sel_n(chip_sel_n), .chip_sel(chip_sel),
        .wr_n(wr_n), .rd_oe_n(rd_oe_n), .lane_en_n(lane_en_n), .addr(addr),
        .wdata(wdata), .rdata(rdata), .lane_drive(lane_drive), .standby(standby)
    );

    function automatic logic [15:0] pattern(input int a, input int salt);
        return 16'((a * 40503 + salt * 977 + 4660) ^ (a >> 3));
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Drive one cycle after a falling edge, sample at the next falling edge.
    task automatic apply(input logic csn, input logic cs, input logic wrn,
                         input logic oen, input logic [1:0] len,
                         input logic [AW-1:0] a, input logic [15:0] d,
                         input string dtag);
        bit sel, wr, rd, sb;
        logic [1:0] exp_drv;
        int idx;
        string dv_tag;
        chip_sel_n = csn; chip_sel = cs; wr_n = wrn; rd_oe_n = oen;
        lane_en_n = len; addr = a; wdata = d;
        @(negedge clk);
        idx = int'(a % DEPTH);
        sel = !csn && cs;
        wr  = sel && !wrn && !(&len);
        rd  = sel && !oen && wrn && !(&len);
        sb  = !sel || (&len);
        exp_drv = rd ? ~len : 2'b00;
        if (!sel)            dv_tag = "R1";
        else if (wr && !oen) dv_tag = "R7";
        else if (!rd)        dv_tag = "R6";
        else if (&exp_drv)   dv_tag = "R4";
        else                 dv_tag = "R5";
        check(lane_drive == exp_drv, dv_tag, 32'(lane_drive), 32'(exp_drv));
        check(standby == sb, "R8", 32'(standby), 32'(sb));
        if (exp_drv[0])
            check(rdata[7:0] == ref_mem[idx][7:0], dtag, 32'(rdata[7:0]),
                  32'(ref_mem[idx][7:0]));
        if (exp_drv[1])
            check(rdata[15:8] == ref_mem[idx][15:8], dtag, 32'(rdata[15:8]),
                  32'(ref_mem[idx][15:8]));
        if (wr) begin
            if (!len[0]) ref_mem[idx][7:0]  = d[7:0];
            if (!len[1]) ref_mem[idx][15:8] = d[15:8];
        end
    endtask

    task automatic wr_word(input logic [AW-1:0] a, input logic [1:0] len,
                           input logic [15:0] d);
        apply(1'b0, 1'b1, 1'b0, 1'b1, len, a, d, "R2");
    endtask

    task automatic rd_word(input logic [AW-1:0] a, input logic [1:0] len,
                           input string tag);
        apply(1'b0, 1'b1, 1'b1, 1'b0, len, a, 16'h0, tag);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) ref_mem[i] = 16'h0;
        repeat (3) @(negedge clk);
        // R9: quiet outputs while held in reset
        check(standby == 1'b1, "R9", 32'(standby), 32'd1);
        check(lane_drive == 2'b00, "R9", 32'(lane_drive), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: fill every word through both lanes
        for (int a = 0; a < DEPTH; a++) wr_word(AW'(a), 2'b00, pattern(a, 1));
        // R4: read every word back through both lanes
        for (int a = 0; a < DEPTH; a++) rd_word(AW'(a), 2'b00, "R4");

        // R3: single-lane writes keep the other lane
        for (int a = 0; a < 256; a++)
            wr_word(AW'(a), (a % 2 == 0) ? 2'b10 : 2'b01, pattern(a, 7));
        for (int a = 0; a < 256; a++) rd_word(AW'(a), 2'b00, "R3");
        // R5: single-lane reads
        for (int a = 0; a < 64; a++) rd_word(AW'(a), 2'b10, "R5");
        for (int a = 0; a < 64; a++) rd_word(AW'(a), 2'b01, "R5");

        // R1 R6 R7 R8: every control combination, twice over different words
        for (int pass = 0; pass < 2; pass++) begin
            for (int c = 0; c < 64; c++) begin
                int a;
                a = 300 + c * 5 + pass;
                apply(c[5], c[4], c[3], c[2], c[1:0], AW'(a), pattern(a, 11 + pass), "R4");
                rd_word(AW'(a), 2'b00, "R1");
            end
        end

        // R10: upper address bits alias onto the same word
        for (int k = 1; k < 4; k++) begin
            wr_word(AW'((k << 10) | 5), 2'b00, pattern(k, 23));
            rd_word(AW'(5), 2'b00, "R10");
            rd_word(AW'((k << 12) | 5), 2'b00, "R10");
        end
        rd_word(AW'((1 << 19) | 1023), 2'b00, "R10");

        // R7: write priority with output enable asserted, then read back
        apply(1'b0, 1'b1, 1'b0, 1'b0, 2'b00, AW'(900), 16'hC3A5, "R7");
        rd_word(AW'(900), 2'b00, "R7");

        // back to deselected
        apply(1'b1, 1'b0, 1'b1, 1'b1, 2'b11, AW'(0), 16'h0, "R8");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule